// File: doc/BRIEF.md
# ALU Condition Flag Status Register

This block keeps the low byte of a processor status word. Each time the ALU signals a completed operation, it can refresh up to five condition flags. Three of them are computed inside the block. The negative flag takes the sign bit of the result. The zero flag tests whether the result is zero. The end-of-table flag detects the most negative source operand. The carry and overflow flags are copied from the ALU. The width used for these tests is 16 bits in word mode and 8 bits in byte mode.

A five-bit update mask comes with each ALU strobe and selects which flags the instruction is allowed to change. A software write port can replace the whole byte. That write wins over any hardware update in the same cycle. Two user flags change only through this write port. The multiply/divide-in-progress position is hard-wired to zero. The read port shows the registered byte, so a read always reflects the state left by the previous instruction.

Top module: `alu_flag_status`

## Requirements
- R1: Reset (rstN low, asynchronous) clears all eight status bits to 0.
- R2: On an enabled ALU update, the negative flag (bit 0) takes result bit 15 in word mode (byteMode=0) and result bit 7 in byte mode (byteMode=1).
- R3: On an enabled ALU update, the zero flag (bit 3) is 1 exactly when the result is zero. In byte mode only result bits 7..0 are tested and the upper byte is ignored.
- R4: On an enabled ALU update, the end-of-table flag (bit 4) is 1 exactly when srcOp equals 16'h8000 in word mode, or when srcOp bits 7..0 equal 8'h80 in byte mode.
- R5: On an enabled ALU update, the carry flag (bit 1) takes carryIn and the overflow flag (bit 2) takes ovflIn.
- R6: updMask bit k enables flag bit k (0 N, 1 C, 2 V, 3 Z, 4 E) on an aluUpd strobe. Flags that are not enabled, and all flags in a cycle without aluUpd or swWrEn, keep their value.
- R7: When swWrEn is high, the register loads swWrData at the clock edge, and any ALU update in the same cycle is discarded.
- R8: Bit 5 (multiply/divide in progress) always reads 0, and writes to it are ignored.
- R9: The user flags (bits 6 and 7) change only on a software write. ALU updates never alter them.
- R10: rdData is the registered value. While an update is pending before its clock edge, rdData still shows the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aluUpd | input | 1 | ALU update strobe |
| byteMode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit operation |
| result | input | 16 | ALU result |
| srcOp | input | 16 | ALU source operand |
| carryIn | input | 1 | Carry/borrow produced by the ALU |
| ovflIn | input | 1 | Overflow produced by the ALU |
| updMask | input | 5 | Per-flag update enable {E,Z,V,C,N} |
| swWrEn | input | 1 | Explicit software write enable |
| swWrData | input | 8 | Explicit software write data |
| rdData | output | 8 | Status byte read value |

## Verification
The assertions assume that every data input (result, srcOp, carryIn, ovflIn, updMask, byteMode, swWrData) is known whenever a strobe is high. The bench therefore drives all of them to defined values from time zero and changes them only at falling clock edges. The bench also holds reset over several edges, so every $past sample taken after reset refers to driven values. Each vector first presets the byte through the write port and then applies a single ALU strobe, so the expected byte depends only on that vector.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int STAT_W    = 8;
  localparam int BIT_N     = 0;
  localparam int BIT_C     = 1;
  localparam int BIT_V     = 2;
  localparam int BIT_Z     = 3;
  localparam int BIT_E     = 4;
  localparam int BIT_BUSY  = 5;
  localparam int BIT_USR0  = 6;
  localparam int BIT_USR1  = 7;

  typedef struct packed {
    logic                 loadSw;
    logic [NUM_FLAGS-1:0] flagEn;
  } strobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic                 aluUpd,
  input  logic                 swWrEn,
  input  logic [NUM_FLAGS-1:0] updMask,
  output strobe_t              strobe
);
  always_comb begin
    strobe.loadSw = swWrEn;
    // explicit write suppresses every implicit flag update
    if (aluUpd && !swWrEn) strobe.flagEn = updMask;
    else                   strobe.flagEn = '0;
  end
endmodule

// File: rtl/flag_dpath.sv
module flag_dpath
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] srcOp,
  input  logic              carryIn,
  input  logic              ovflIn,
  input  logic [STAT_W-1:0] swWrData,
  output logic [STAT_W-1:0] statusQ
);
  localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [BYTE_W-1:0] BYTE_MIN = {1'b1, {(BYTE_W-1){1'b0}}};

  logic [NUM_FLAGS-1:0] calcFlag;
  logic [STAT_W-1:0]    nextQ;

  always_comb begin
    calcFlag        = '0;
    calcFlag[BIT_C] = carryIn;
    calcFlag[BIT_V] = ovflIn;
    if (byteMode) begin
      calcFlag[BIT_N] = result[BYTE_W-1];
      calcFlag[BIT_Z] = (result[BYTE_W-1:0] == '0);
      calcFlag[BIT_E] = (srcOp[BYTE_W-1:0] == BYTE_MIN);
    end else begin
      calcFlag[BIT_N] = result[DATA_W-1];
      calcFlag[BIT_Z] = (result == '0);
      calcFlag[BIT_E] = (srcOp == WORD_MIN);
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb begin
      if (strobe.loadSw)       nextQ[i] = swWrData[i];
      else if (strobe.flagEn[i]) nextQ[i] = calcFlag[i];
      else                     nextQ[i] = statusQ[i];
    end
  end

  assign nextQ[BIT_BUSY] = 1'b0;

  for (genvar u = BIT_USR0; u <= BIT_USR1; u++) begin : g_usr
    assign nextQ[u] = strobe.loadSw ? swWrData[u] : statusQ[u];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= nextQ;
  end
endmodule

// File: rtl/alu_flag_status.sv
module alu_flag_status
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluUpd,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] srcOp,
  input  logic              carryIn,
  input  logic              ovflIn,
  input  logic [4:0]        updMask,
  input  logic              swWrEn,
  input  logic [7:0]        swWrData,
  output logic [7:0]        rdData
);
  strobe_t strobe;

  flag_ctrl u_ctrl (
    .aluUpd  (aluUpd),
    .swWrEn  (swWrEn),
    .updMask (updMask),
    .strobe  (strobe)
  );

  flag_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .byteMode (byteMode),
    .result   (result),
    .srcOp    (srcOp),
    .carryIn  (carryIn),
    .ovflIn   (ovflIn),
    .swWrData (swWrData),
    .statusQ  (rdData)
  );
endmodule

// File: rtl/alu_flag_status_chk.sv
module alu_flag_status_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              aluUpd,
  input logic              byteMode,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] srcOp,
  input logic              carryIn,
  input logic              ovflIn,
  input logic [4:0]        updMask,
  input logic              swWrEn,
  input logic [7:0]        swWrData,
  input logic [7:0]        rdData
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdData == 8'h00); // R1

  AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5] == 1'b0); // R8

  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> rdData == {$past(swWrData[7:6]), 1'b0, $past(swWrData[4:0])}); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && !aluUpd) |=> $stable(rdData)); // R6

  AST_USR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> rdData[7:6] == $past(rdData[7:6])); // R9

  AST_CARRY_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (aluUpd && !swWrEn && updMask[1]) |=> rdData[1] == $past(carryIn)); // R5

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (aluUpd && !swWrEn && updMask[3]) |=>
      rdData[3] == ($past(byteMode) ? ($past(result[BYTE_W-1:0]) == '0)
                                    : ($past(result) == '0))); // R3
endmodule

bind alu_flag_status alu_flag_status_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .aluUpd(aluUpd), .byteMode(byteMode),
  .result(result), .srcOp(srcOp), .carryIn(carryIn), .ovflIn(ovflIn),
  .updMask(updMask), .swWrEn(swWrEn), .swWrData(swWrData), .rdData(rdData)
);

// File: tb/alu_flag_status_bench.sv
module alu_flag_status_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aluUpd = 1'b0;
  logic        byteMode = 1'b0;
  logic [15:0] result = '0;
  logic [15:0] srcOp = '0;
  logic        carryIn = 1'b0;
  logic        ovflIn = 1'b0;
  logic [4:0]  updMask = '0;
  logic        swWrEn = 1'b0;
  logic [7:0]  swWrData = '0;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  alu_flag_status u_alu_flag_status (
    .clk(clk), .rstN(rstN), .aluUpd(aluUpd), .byteMode(byteMode),
    .result(result), .srcOp(srcOp), .carryIn(carryIn), .ovflIn(ovflIn),
    .updMask(updMask), .swWrEn(swWrEn), .swWrData(swWrData), .rdData(rdData)
  );

  // {pre[7:0], byteMode, result[15:0], srcOp[15:0], carry, ovfl, mask[4:0], expect[7:0]}
  localparam logic [55:0] VEC [0:9] = '{
    {8'h00, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b0, 5'h1F, 8'h13}, // R2 R4 R5 word sign, min operand
    {8'h00, 1'b0, 16'h0000, 16'h1234, 1'b0, 1'b1, 5'h1F, 8'h0C}, // R3 R5 word zero, overflow
    {8'h00, 1'b1, 16'h1200, 16'h0080, 1'b0, 1'b0, 5'h1F, 8'h18}, // R3 R4 byte zero ignores upper
    {8'h00, 1'b1, 16'h0080, 16'h8000, 1'b1, 1'b1, 5'h1F, 8'h07}, // R2 R4 byte sign, 8000 not min
    {8'h00, 1'b0, 16'h0080, 16'h0080, 1'b0, 1'b0, 5'h1F, 8'h00}, // R2 R4 word ignores bit 7 / 80
    {8'h1F, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0, 5'h00, 8'h1F}, // R6 empty mask
    {8'h1F, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0, 5'h01, 8'h1E}, // R6 only N
    {8'hC0, 1'b0, 16'h0000, 16'h8000, 1'b1, 1'b1, 5'h1F, 8'hDE}, // R9 user bits kept
    {8'h0F, 1'b0, 16'hFFFF, 16'h7FFF, 1'b0, 1'b0, 5'h0A, 8'h05}, // R6 C and Z only
    {8'h20, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 5'h00, 8'h00}  // R8 busy bit write ignored
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic swWrite(input logic [7:0] d);
    @(negedge clk);
    swWrEn = 1'b1; swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset value", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", rdData, 8'h00);

    for (int i = 0; i < 10; i++) begin
      logic [55:0] v;
      v = VEC[i];
      swWrite(v[55:48]);
      byteMode = v[47]; result = v[46:31]; srcOp = v[30:15];
      carryIn = v[14]; ovflIn = v[13]; updMask = v[12:8];
      aluUpd = 1'b1;
      @(negedge clk);
      aluUpd = 1'b0;
      check($sformatf("R2/R3/R4/R5/R6/R8/R9 vector %0d", i), rdData, v[7:0]);
    end

    // R10: pending update not visible before its edge
    swWrite(8'h40);
    result = 16'h0000; srcOp = 16'h8000; byteMode = 1'b0; updMask = 5'h1F;
    carryIn = 1'b1; ovflIn = 1'b1;
    aluUpd = 1'b1;
    #1;
    check("R10 before edge", rdData, 8'h40);
    @(negedge clk);
    aluUpd = 1'b0;
    check("R10 after edge", rdData, 8'h5E);

    // R6: idle cycles hold
    repeat (3) @(negedge clk);
    check("R6 idle hold", rdData, 8'h5E);

    // R7: write and ALU update in the same cycle
    swWrEn = 1'b1; swWrData = 8'hA5; aluUpd = 1'b1; updMask = 5'h1F;
    result = 16'h0000; srcOp = 16'h8000; carryIn = 1'b0; ovflIn = 1'b1;
    @(negedge clk);
    swWrEn = 1'b0; aluUpd = 1'b0;
    check("R7 write priority", rdData, 8'h85);

    // R9: ALU update with full mask leaves user bits
    swWrite(8'hFF);
    check("R8 write FF", rdData, 8'hDF);
    result = 16'h1234; srcOp = 16'h0000; carryIn = 1'b0; ovflIn = 1'b0;
    aluUpd = 1'b1;
    @(negedge clk);
    aluUpd = 1'b0;
    check("R9 user bits after ALU", rdData, 8'hC0);

    // R1: reset mid-run
    rstN = 1'b0;
    #1;
    check("R1 async reset", rdData, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after second reset", rdData, 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule